// File: doc/BRIEF.md
# Synchronous Clock Output Stop Controller

This block sits between the clock generators and the output pins of a clock source device. It receives already generated source clocks (a 33 MHz bus clock domain, a CPU host clock domain, a 48 MHz domain and a 66 MHz domain) and decides, output by output, whether each one toggles or rests at a parked level. The inputs that control it are two active-low stop pins and a set of configuration bits: per-output enables, a software PCI run bit, per-output "obey stop" bits for the free-run-capable bus clocks, and per-pair free-run bits for the CPU pairs.

Each output has its own gate cell with its own two-flop synchronizer, clocked by that output's source clock. The cell has two states. In GATE_PARKED the output rests at its park level. In GATE_RUNNING it follows the source clock. The transition OPEN (GATE_PARKED to GATE_RUNNING) and the transition CLOSE (GATE_RUNNING to GATE_PARKED) are taken only on the source edge that leaves the clock at the park level. Because of this, the first and the last pulse always have full width. Bus, 48 MHz and 66 MHz outputs park low. The CPU true output parks high. Its complement is the inverse of the true output, so a pair always moves as one.

Top module: `clk_stop_ctrl`

## Requirements
- R1: Stoppable bus clock `pci_clk[i]` toggles only while `cfg_pci_en[i]`=1 and the internal bus stop is released. Otherwise it rests low.
- R2: The internal bus stop is released only when both `pci_stop_n`=1 and `cfg_pci_run`=1. Clearing `cfg_pci_run` with the pin high stops the stoppable bus clocks exactly as a low pin does.
- R3: A free-run-capable bus clock `pcif_clk[j]` with `cfg_pcif_stoppable[j]`=0 keeps toggling whatever the bus stop does. With the bit at 1 it rests low while the internal bus stop is asserted. With `cfg_pcif_en[j]`=0 it rests low in every case.
- R4: While `cpu_stop_n`=0, every CPU pair whose free-run bit is 0 rests with `cpu_clk_t`=1 and `cpu_clk_c`=0. At every instant `cpu_clk_c` is the inverse of `cpu_clk_t`.
- R5: A CPU pair with `cfg_cpu_freerun[k]`=1 keeps toggling while `cpu_stop_n`=0.
- R6: With `cfg_cpu_en[k]`=0, pair k rests with true high and complement low, independent of `cpu_stop_n` and the free-run bit.
- R7: `f48_clk[i]` and `f66_clk[i]` toggle when their enable bit is 1 and rest low when it is 0.
- R8: A gate changes state only while its source clock is at the park level. No high pulse of a low-parked output, and no low pulse of a high-parked output, is shorter than a source half period.
- R9: After a control change, the output reaches its new state within three cycles of its own source clock. After a stop is released, it resumes with full pulses.
- R10: While `rst_n`=0, every output is parked: CPU true outputs high and all other outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci_src | input | 1 | Source for stoppable and free-run-capable bus clocks |
| clk_cpu_src | input | 1 | Source for CPU pairs |
| clk_48_src | input | 1 | Source for 48 MHz outputs |
| clk_66_src | input | 1 | Source for 66 MHz outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_stop_n | input | 1 | Active-low bus clock stop pin |
| cpu_stop_n | input | 1 | Active-low CPU clock stop pin |
| cfg_pci_run | input | 1 | Software bus run bit, ANDed with the pin |
| cfg_pci_en | input | N_PCI | Enables of stoppable bus clocks |
| cfg_pcif_en | input | N_PCIF | Enables of free-run-capable bus clocks |
| cfg_pcif_stoppable | input | N_PCIF | 1 = that clock obeys the bus stop |
| cfg_cpu_en | input | N_CPU | CPU pair enables |
| cfg_cpu_freerun | input | N_CPU | 1 = pair ignores the CPU stop |
| cfg_f48_en | input | N_F48 | Enables of 48 MHz outputs |
| cfg_f66_en | input | N_F66 | Enables of 66 MHz outputs |
| pci_clk | output | N_PCI | Gated stoppable bus clocks |
| pcif_clk | output | N_PCIF | Gated free-run-capable bus clocks |
| cpu_clk_t | output | N_CPU | Gated CPU true clocks |
| cpu_clk_c | output | N_CPU | Gated CPU complement clocks |
| f48_clk | output | N_F48 | Gated 48 MHz clocks |
| f66_clk | output | N_F66 | Gated 66 MHz clocks |

## Verification
A control change is captured on the first synchronizer edge, passes the second one cycle later, and takes effect on the following park-level edge. Each output therefore settles at most two and a half of its own source cycles after the stimulus. After every stimulus the bench waits 120 ns, which is four cycles of the slowest (30 ns) source. It then samples all outputs every nanosecond for 120 ns, at half-nanosecond offsets from every clock edge, and classifies each output as toggling, resting high or resting low. A separate monitor measures every pulse of chosen outputs over the whole run to catch runt pulses.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;

    // Gate cell state: parked at the rest level or following the source
    typedef enum logic {
        GATE_PARKED  = 1'b0,
        GATE_RUNNING = 1'b1
    } gate_state_e;

    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/clk_stop_req.sv
`timescale 1ns/1ps
module clk_stop_req #(
    parameter int N_PCI  = 7,
    parameter int N_PCIF = 3,
    parameter int N_CPU  = 3,
    parameter int N_F48  = 2,
    parameter int N_F66  = 6
) (
    input  logic              pci_stop_n,
    input  logic              cpu_stop_n,
    input  logic              cfg_pci_run,
    input  logic [N_PCI-1:0]  cfg_pci_en,
    input  logic [N_PCIF-1:0] cfg_pcif_en,
    input  logic [N_PCIF-1:0] cfg_pcif_stoppable,
    input  logic [N_CPU-1:0]  cfg_cpu_en,
    input  logic [N_CPU-1:0]  cfg_cpu_freerun,
    input  logic [N_F48-1:0]  cfg_f48_en,
    input  logic [N_F66-1:0]  cfg_f66_en,
    output logic [N_PCI-1:0]  pci_req,
    output logic [N_PCIF-1:0] pcif_req,
    output logic [N_CPU-1:0]  cpu_req,
    output logic [N_F48-1:0]  f48_req,
    output logic [N_F66-1:0]  f66_req
);

    // Bus stop is released only when pin and software bit both allow it
    logic bus_go;
    assign bus_go = pci_stop_n & cfg_pci_run;

    always_comb begin
        pci_req  = cfg_pci_en & {N_PCI{bus_go}};
        pcif_req = cfg_pcif_en & (~cfg_pcif_stoppable | {N_PCIF{bus_go}});
        cpu_req  = cfg_cpu_en & (cfg_cpu_freerun | {N_CPU{cpu_stop_n}});
        f48_req  = cfg_f48_en;
        f66_req  = cfg_f66_en;
    end

endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell
    import clk_stop_pkg::*;
#(
    parameter bit PARK_HIGH   = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic run_req,
    output logic clk_out
);

    localparam logic PARK_LVL = PARK_HIGH;
    localparam int   CNT_W    = $clog2(SYNC_STAGES + 2) + 1;

    // Edge on which the source reaches the park level
    logic upd_clk;
    generate
        if (PARK_HIGH) begin : g_park_hi
            assign upd_clk = src_clk;
        end else begin : g_park_lo
            assign upd_clk = ~src_clk;
        end
    endgenerate

    // Synchronizer samples on the opposite edge
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   req_s;

    always_ff @(negedge upd_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], run_req};
    end
    assign req_s = sync_q[SYNC_STAGES-1];

    gate_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            GATE_PARKED:  state_d = req_s ? GATE_RUNNING : GATE_PARKED;  // OPEN
            GATE_RUNNING: state_d = req_s ? GATE_RUNNING : GATE_PARKED;  // CLOSE
            default:      state_d = GATE_PARKED;
        endcase
    end

    always_ff @(posedge upd_clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_PARKED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            GATE_PARKED:  clk_out = PARK_LVL;
            GATE_RUNNING: clk_out = src_clk;
            default:      clk_out = PARK_LVL;
        endcase
    end

    // Checker state: how long the raw request has been steady
    logic             last_req;
    logic [CNT_W-1:0] stable_cnt;

    always_ff @(negedge upd_clk or negedge rst_n) begin
        if (!rst_n) begin
            last_req   <= 1'b0;
            stable_cnt <= '0;
        end else begin
            last_req <= run_req;
            if (run_req == last_req) begin
                if (stable_cnt != '1) stable_cnt <= stable_cnt + 1'b1;
            end else begin
                stable_cnt <= '0;
            end
        end
    end

    always @(state_q) begin
        if (rst_n) begin
            AST_GATE_AT_PARK: assert (src_clk == PARK_LVL);  // R8
        end
    end

    AST_CLOSE_SETTLES: assert property (@(negedge upd_clk) disable iff (!rst_n)
        (stable_cnt >= CNT_W'(SYNC_STAGES + 1) && !last_req) |-> (state_q == GATE_PARKED));  // R9

    AST_OPEN_SETTLES: assert property (@(negedge upd_clk) disable iff (!rst_n)
        (stable_cnt >= CNT_W'(SYNC_STAGES + 1) && last_req) |-> (state_q == GATE_RUNNING));  // R9

    AST_HOLD_PARKED: assert property (@(posedge upd_clk) disable iff (!rst_n)
        (state_q == GATE_PARKED && !req_s) |=> (state_q == GATE_PARKED));  // R9

endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl #(
    parameter int N_PCI       = 7,
    parameter int N_PCIF      = 3,
    parameter int N_CPU       = 3,
    parameter int N_F48       = 2,
    parameter int N_F66       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_pci_src,
    input  logic              clk_cpu_src,
    input  logic              clk_48_src,
    input  logic              clk_66_src,
    input  logic              rst_n,
    input  logic              pci_stop_n,
    input  logic              cpu_stop_n,
    input  logic              cfg_pci_run,
    input  logic [N_PCI-1:0]  cfg_pci_en,
    input  logic [N_PCIF-1:0] cfg_pcif_en,
    input  logic [N_PCIF-1:0] cfg_pcif_stoppable,
    input  logic [N_CPU-1:0]  cfg_cpu_en,
    input  logic [N_CPU-1:0]  cfg_cpu_freerun,
    input  logic [N_F48-1:0]  cfg_f48_en,
    input  logic [N_F66-1:0]  cfg_f66_en,
    output logic [N_PCI-1:0]  pci_clk,
    output logic [N_PCIF-1:0] pcif_clk,
    output logic [N_CPU-1:0]  cpu_clk_t,
    output logic [N_CPU-1:0]  cpu_clk_c,
    output logic [N_F48-1:0]  f48_clk,
    output logic [N_F66-1:0]  f66_clk
);

    logic [N_PCI-1:0]  pci_req;
    logic [N_PCIF-1:0] pcif_req;
    logic [N_CPU-1:0]  cpu_req;
    logic [N_F48-1:0]  f48_req;
    logic [N_F66-1:0]  f66_req;

    clk_stop_req #(
        .N_PCI(N_PCI), .N_PCIF(N_PCIF), .N_CPU(N_CPU),
        .N_F48(N_F48), .N_F66(N_F66)
    ) u_req (
        .pci_stop_n         (pci_stop_n),
        .cpu_stop_n         (cpu_stop_n),
        .cfg_pci_run        (cfg_pci_run),
        .cfg_pci_en         (cfg_pci_en),
        .cfg_pcif_en        (cfg_pcif_en),
        .cfg_pcif_stoppable (cfg_pcif_stoppable),
        .cfg_cpu_en         (cfg_cpu_en),
        .cfg_cpu_freerun    (cfg_cpu_freerun),
        .cfg_f48_en         (cfg_f48_en),
        .cfg_f66_en         (cfg_f66_en),
        .pci_req            (pci_req),
        .pcif_req           (pcif_req),
        .cpu_req            (cpu_req),
        .f48_req            (f48_req),
        .f66_req            (f66_req)
    );

    generate
        for (genvar i = 0; i < N_PCI; i++) begin : g_pci
            clk_gate_cell #(.PARK_HIGH(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_gate (
                .src_clk(clk_pci_src), .rst_n(rst_n),
                .run_req(pci_req[i]), .clk_out(pci_clk[i]));
        end
        for (genvar j = 0; j < N_PCIF; j++) begin : g_pcif
            clk_gate_cell #(.PARK_HIGH(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_gate (
                .src_clk(clk_pci_src), .rst_n(rst_n),
                .run_req(pcif_req[j]), .clk_out(pcif_clk[j]));
        end
        for (genvar k = 0; k < N_CPU; k++) begin : g_cpu
            clk_gate_cell #(.PARK_HIGH(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_gate (
                .src_clk(clk_cpu_src), .rst_n(rst_n),
                .run_req(cpu_req[k]), .clk_out(cpu_clk_t[k]));
            // Complement parks low when true parks high; one gate drives both
            assign cpu_clk_c[k] = ~cpu_clk_t[k];
        end
        for (genvar m = 0; m < N_F48; m++) begin : g_f48
            clk_gate_cell #(.PARK_HIGH(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_gate (
                .src_clk(clk_48_src), .rst_n(rst_n),
                .run_req(f48_req[m]), .clk_out(f48_clk[m]));
        end
        for (genvar n = 0; n < N_F66; n++) begin : g_f66
            clk_gate_cell #(.PARK_HIGH(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_gate (
                .src_clk(clk_66_src), .rst_n(rst_n),
                .run_req(f66_req[n]), .clk_out(f66_clk[n]));
        end
    endgenerate

endmodule

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/100ps
module clk_stop_ctrl_tb_top;

    localparam int ST_LOW = 0;
    localparam int ST_HIGH = 1;
    localparam int ST_RUN = 2;

    logic       clk_tb = 1'b0;
    logic       clk_pci = 1'b0;
    logic       clk_48 = 1'b0;
    logic       clk_66 = 1'b0;
    logic       rst_n = 1'b0;
    logic       pci_stop_n = 1'b1;
    logic       cpu_stop_n = 1'b1;
    logic       cfg_pci_run = 1'b1;
    logic [6:0] cfg_pci_en = 7'h7f;
    logic [2:0] cfg_pcif_en = 3'b111;
    logic [2:0] cfg_pcif_stoppable = 3'b000;
    logic [2:0] cfg_cpu_en = 3'b111;
    logic [2:0] cfg_cpu_freerun = 3'b000;
    logic [1:0] cfg_f48_en = 2'b11;
    logic [5:0] cfg_f66_en = 6'h3f;

    logic [6:0] pci_clk;
    logic [2:0] pcif_clk;
    logic [2:0] cpu_clk_t;
    logic [2:0] cpu_clk_c;
    logic [1:0] f48_clk;
    logic [5:0] f66_clk;

    always #4  clk_tb  = ~clk_tb;   // 125 MHz, CPU source
    always #15 clk_pci = ~clk_pci;
    always #10 clk_48  = ~clk_48;
    always #7  clk_66  = ~clk_66;

    clk_stop_ctrl dut_i (
        .clk_pci_src(clk_pci), .clk_cpu_src(clk_tb), .clk_48_src(clk_48),
        .clk_66_src(clk_66), .rst_n(rst_n), .pci_stop_n(pci_stop_n),
        .cpu_stop_n(cpu_stop_n), .cfg_pci_run(cfg_pci_run),
        .cfg_pci_en(cfg_pci_en), .cfg_pcif_en(cfg_pcif_en),
        .cfg_pcif_stoppable(cfg_pcif_stoppable), .cfg_cpu_en(cfg_cpu_en),
        .cfg_cpu_freerun(cfg_cpu_freerun), .cfg_f48_en(cfg_f48_en),
        .cfg_f66_en(cfg_f66_en), .pci_clk(pci_clk), .pcif_clk(pcif_clk),
        .cpu_clk_t(cpu_clk_t), .cpu_clk_c(cpu_clk_c), .f48_clk(f48_clk),
        .f66_clk(f66_clk)
    );

    logic [23:0] obs;
    assign obs = {f66_clk, f48_clk, cpu_clk_c, cpu_clk_t, pcif_clk, pci_clk};

    int n_checks = 0;
    int n_fail = 0;
    int runts = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected rest/run state from the requirements
    function automatic int expect_of(input int idx, input bit in_reset);
        bit bus_go;
        bus_go = pci_stop_n & cfg_pci_run;
        if (in_reset) return (idx >= 10 && idx < 13) ? ST_HIGH : ST_LOW;
        if (idx < 7)  return (cfg_pci_en[idx] && bus_go) ? ST_RUN : ST_LOW;
        if (idx < 10) return (cfg_pcif_en[idx-7] && (!cfg_pcif_stoppable[idx-7] || bus_go))
                              ? ST_RUN : ST_LOW;
        if (idx < 13) return (cfg_cpu_en[idx-10] && (cfg_cpu_freerun[idx-10] || cpu_stop_n))
                              ? ST_RUN : ST_HIGH;
        if (idx < 16) return (cfg_cpu_en[idx-13] && (cfg_cpu_freerun[idx-13] || cpu_stop_n))
                              ? ST_RUN : ST_LOW;
        if (idx < 18) return cfg_f48_en[idx-16] ? ST_RUN : ST_LOW;
        return cfg_f66_en[idx-18] ? ST_RUN : ST_LOW;
    endfunction

    function automatic string group_of(input int idx);
        if (idx < 7)  return "R1";
        if (idx < 10) return "R3";
        if (idx < 16) return "R4";
        return "R7";
    endfunction

    // Sample all outputs for 120 ns and compare their behaviour
    task automatic observe(input string tag, input bit in_reset);
        logic [23:0] seen_hi = '0;
        logic [23:0] seen_lo = '0;
        int pair_bad = 0;
        for (int s = 0; s < 120; s++) begin
            #1;
            seen_hi |= obs;
            seen_lo |= ~obs;
            if (cpu_clk_c !== ~cpu_clk_t) pair_bad++;
        end
        for (int idx = 0; idx < 24; idx++) begin
            int act;
            int exp;
            act = (seen_hi[idx] && seen_lo[idx]) ? ST_RUN : (seen_hi[idx] ? ST_HIGH : ST_LOW);
            exp = expect_of(idx, in_reset);
            check(act == exp, {tag, "/", group_of(idx)},
                  $sformatf("output bit %0d state", idx), act, exp);
        end
        check(pair_bad == 0, {tag, "/R4"}, "complement mismatches", pair_bad, 0);
    endtask

    task automatic settle_and_observe(input string tag);
        #120;
        observe(tag, 1'b0);
    endtask

    task automatic t_reset();       // R10
        #2;
        observe("R10", 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic t_defaults();    // R1 R3 R7 all running
        settle_and_observe("R1");
    endtask

    task automatic t_pci_pin();     // R1: pin stops bus clocks, free-run ones keep going
        pci_stop_n = 1'b0;
        settle_and_observe("R1");
    endtask

    task automatic t_pcif_modes();  // R3
        cfg_pcif_stoppable = 3'b101;
        cfg_pcif_en = 3'b101;
        settle_and_observe("R3");
        cfg_pcif_en = 3'b111;
        cfg_pcif_stoppable = 3'b010;
        settle_and_observe("R3");
    endtask

    task automatic t_pci_reg();     // R2
        pci_stop_n = 1'b1;
        cfg_pci_run = 1'b0;
        cfg_pci_en = 7'b1011101;
        settle_and_observe("R2");
        cfg_pci_run = 1'b1;
        settle_and_observe("R2");
    endtask

    task automatic t_cpu_stop();    // R4
        cpu_stop_n = 1'b0;
        settle_and_observe("R4");
    endtask

    task automatic t_cpu_freerun(); // R5
        cfg_cpu_freerun = 3'b010;
        settle_and_observe("R5");
    endtask

    task automatic t_cpu_disable(); // R6
        cpu_stop_n = 1'b1;
        cfg_cpu_freerun = 3'b001;
        cfg_cpu_en = 3'b110;
        settle_and_observe("R6");
    endtask

    task automatic t_fixed_en();    // R7
        cfg_f48_en = 2'b01;
        cfg_f66_en = 6'b101010;
        settle_and_observe("R7");
    endtask

    task automatic t_resume();      // R9
        cfg_pci_en = 7'h7f;
        cfg_pcif_stoppable = 3'b000;
        cfg_cpu_en = 3'b111;
        cfg_cpu_freerun = 3'b000;
        cfg_f48_en = 2'b11;
        cfg_f66_en = 6'h3f;
        pci_stop_n = 1'b0;
        cpu_stop_n = 1'b0;
        #120;
        pci_stop_n = 1'b1;
        cpu_stop_n = 1'b1;
        #90;                        // three cycles of the slowest source
        observe("R9", 1'b0);
    endtask

    // Runt monitor on a low-parked bus clock and a CPU complement (R8)
    initial begin
        int run_p = 0;
        int run_c = 0;
        #0.5;
        forever begin
            #1;
            if (rst_n) begin
                if (pci_clk[0]) run_p++;
                else begin
                    if (run_p > 0 && run_p < 15) runts++;
                    run_p = 0;
                end
                if (cpu_clk_c[0]) run_c++;
                else begin
                    if (run_c > 0 && run_c < 4) runts++;
                    run_c = 0;
                end
            end
        end
    end

    initial begin
        #50000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #0.5;
        t_reset();
        t_defaults();
        t_pci_pin();
        t_pcif_modes();
        t_pci_reg();
        t_cpu_stop();
        t_cpu_freerun();
        t_cpu_disable();
        t_fixed_en();
        t_resume();
        check(runts == 0, "R8", "runt pulses", runts, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule